// File: doc/BRIEF.md
# Trap Entry Sequencer

This block runs the entry into a trap for a small processor core. Trap sources raise one-cycle request pulses that are latched as pending. Each source has a timing class, fixed at build time. The class decides when the running instruction gives way: at once, at the next iteration boundary of a multi-iteration string instruction, or only when the instruction completes. When the selected trap is taken, the block tells the datapath whether to abort its work. It then holds the program counter and reads the word at the source's own vector address.

That word must be one of two status-swap opcodes. If it is, the block starts the external status-swap exchange and waits for it to finish. If it is not, the block starts a second fetch from the instruction-exception vector. A bad word at that vector as well halts the block through a sticky fatal output. Interrupt acknowledgment is held off from the moment a trap is taken until the swap ends, so an interrupt that becomes ready in that window waits.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the block is idle: trap_active_o, fetch_req_o, swap_go_o, abort_o and fatal_o are 0, and int_ack_o follows int_req_i.
- R2: A taken trap from source s fetches from address 0x040 + 2*s (12-bit address).
- R3: When several sources are pending, the lowest-numbered one is taken first. The others stay pending and are taken later.
- R4: A class-0 (immediate) source is taken in the first cycle it is pending, with no boundary needed, and abort_o is 1 in that cycle.
- R5: A class-1 (iteration) source is taken only in a cycle with iter_bnd_i or insn_bnd_i high, and abort_o is 1 in that cycle so that only the current iteration is dropped.
- R6: A class-2 (end of instruction) source is taken only in a cycle with insn_bnd_i high. iter_bnd_i has no effect on it, and abort_o stays 0. Default classes are source 0: 0, source 1: 1, source 2: 2, source 3: 0.
- R7: trap_active_o (which also means the program counter is held) is 1 from the cycle after the take until the cycle after swap_done_i is seen during the swap.
- R8: A fetched word of 0x8F or 0x8A starts the swap (swap_go_o = 1), with swap_sel_o = 0 for 0x8F and 1 for 0x8A. fetch_req_o is 0 while the swap runs.
- R9: Any other fetched word starts a second fetch, one cycle later, from the instruction-exception vector 0x030.
- R10: An illegal word returned by the instruction-exception fetch sets fatal_o. fatal_o stays set until reset, and no further fetch or swap is issued.
- R11: int_ack_o is 0 whenever trap_active_o is 1, and equals int_req_i otherwise.
- R12: fetch_addr_o stays constant while fetch_req_o is 1 and fetch_ack_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_req_i | input | N_SRC | Trap condition pulses, one bit per source |
| iter_bnd_i | input | 1 | Datapath is at an iteration boundary of a string instruction |
| insn_bnd_i | input | 1 | Datapath is completing the current instruction |
| abort_o | output | 1 | Take cycle: abort the current instruction or iteration |
| trap_active_o | output | 1 | Trap state set; program counter held |
| trap_src_o | output | SW | Source being handled |
| fetch_req_o | output | 1 | Vector fetch request |
| fetch_addr_o | output | AW | Vector fetch address |
| fetch_ack_i | input | 1 | Fetch data valid |
| fetch_data_i | input | OPC_W | Opcode of the fetched vector word |
| swap_go_o | output | 1 | Status-swap exchange in progress |
| swap_sel_o | output | 1 | Which of the two swap opcodes was fetched |
| swap_done_i | input | 1 | Status-swap exchange finished |
| int_req_i | input | 1 | An interrupt level is ready |
| int_ack_o | output | 1 | Interrupt acknowledge, gated by trap entry |
| fatal_o | output | 1 | Sticky halt on a double instruction exception |

## Verification
A table runs one trap from each source, with both legal opcodes and with illegal words that chain to the exception vector. It tells the vector addresses apart from one another and separates a direct swap from a chained one. Directed cases hold back the boundary inputs to separate the three timing classes. In particular, an iteration boundary alone must take a class-1 source but must leave a class-2 source pending. A two-source request tells lowest-number priority apart from arrival order, a delayed acknowledge exposes any address drift, and a double illegal word checks the halt and that it stays set.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SWAP  = 2'd2,
    ST_HALT  = 2'd3
  } tes_state_e;

  typedef enum logic [1:0] {
    TC_IMM  = 2'd0,
    TC_ITER = 2'd1,
    TC_END  = 2'd2,
    TC_ENDX = 2'd3
  } tes_class_e;

  // may a source of this class enter now
  function automatic logic class_go(logic [1:0] cls, logic iter_bnd, logic insn_bnd);
    case (cls)
      TC_IMM:  class_go = 1'b1;
      TC_ITER: class_go = iter_bnd | insn_bnd;
      default: class_go = insn_bnd;
    endcase
  endfunction

  // does entry for this class cut the datapath short
  function automatic logic class_abort(logic [1:0] cls);
    class_abort = (cls == TC_IMM) || (cls == TC_ITER);
  endfunction
endpackage

// File: rtl/tes_prio.sv
module tes_prio #(
  parameter int N_SRC = 4,
  parameter int SW    = 2
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [SW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = SW'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/tes_gate.sv
module tes_gate
  import tes_pkg::*;
#(
  parameter int               N_SRC     = 4,
  parameter int               SW        = 2,
  parameter logic [2*N_SRC-1:0] CLASS_TAB = '0
) (
  input  logic [SW-1:0] idx_i,
  input  logic          iter_bnd_i,
  input  logic          insn_bnd_i,
  output logic          go_o,
  output logic          abort_o
);
  logic [1:0] cls_tab [N_SRC];
  logic [1:0] cls;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cls
    assign cls_tab[g] = CLASS_TAB[2*g +: 2];
  end

  always_comb begin
    cls = TC_ENDX;
    for (int i = 0; i < N_SRC; i++) begin
      if (idx_i == SW'(i)) cls = cls_tab[i];
    end
  end

  assign go_o    = class_go(cls, iter_bnd_i, insn_bnd_i);
  assign abort_o = class_abort(cls);
endmodule

// File: rtl/tes_vec.sv
module tes_vec #(
  parameter int             AW         = 12,
  parameter int             OPC_W      = 8,
  parameter int             SW         = 2,
  parameter logic [AW-1:0]  VEC_BASE   = 12'h040,
  parameter int             VEC_STRIDE = 2,
  parameter logic [OPC_W-1:0] SWAP_OP0 = 8'h8F,
  parameter logic [OPC_W-1:0] SWAP_OP1 = 8'h8A
) (
  input  logic [SW-1:0]    idx_i,
  output logic [AW-1:0]    addr_o,
  input  logic [OPC_W-1:0] op_i,
  output logic             legal_o,
  output logic             sel_o
);
  localparam logic [AW-1:0] STRIDE = AW'(VEC_STRIDE);

  assign addr_o  = VEC_BASE + (AW'(idx_i) * STRIDE);
  assign sel_o   = (op_i == SWAP_OP1);
  assign legal_o = (op_i == SWAP_OP0) || (op_i == SWAP_OP1);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import tes_pkg::*;
#(
  parameter int                 N_SRC      = 4,
  parameter int                 AW         = 12,
  parameter int                 OPC_W      = 8,
  parameter logic [AW-1:0]      VEC_BASE   = 12'h040,
  parameter int                 VEC_STRIDE = 2,
  parameter logic [AW-1:0]      IEX_VEC    = 12'h030,
  parameter logic [OPC_W-1:0]   SWAP_OP0   = 8'h8F,
  parameter logic [OPC_W-1:0]   SWAP_OP1   = 8'h8A,
  parameter logic [2*N_SRC-1:0] CLASS_TAB  = 8'h24,
  localparam int                SW         = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] trap_req_i,
  input  logic             iter_bnd_i,
  input  logic             insn_bnd_i,
  output logic             abort_o,
  output logic             trap_active_o,
  output logic [SW-1:0]    trap_src_o,
  output logic             fetch_req_o,
  output logic [AW-1:0]    fetch_addr_o,
  input  logic             fetch_ack_i,
  input  logic [OPC_W-1:0] fetch_data_i,
  output logic             swap_go_o,
  output logic             swap_sel_o,
  input  logic             swap_done_i,
  input  logic             int_req_i,
  output logic             int_ack_o,
  output logic             fatal_o
);
  tes_state_e st_q, st_d;

  logic [N_SRC-1:0] pend_q, pend_clr;
  logic [AW-1:0]    addr_q, addr_d;
  logic [SW-1:0]    src_q;
  logic             iex_q, iex_d;
  logic             sel_q, sel_d;

  logic             any_pend, win_go, win_abort, take;
  logic [SW-1:0]    win_idx;
  logic [AW-1:0]    win_addr;
  logic             op_legal, op_sel;

  tes_prio #(.N_SRC(N_SRC), .SW(SW)) u_prio (
    .pend_i (pend_q),
    .any_o  (any_pend),
    .idx_o  (win_idx)
  );

  tes_gate #(.N_SRC(N_SRC), .SW(SW), .CLASS_TAB(CLASS_TAB)) u_gate (
    .idx_i      (win_idx),
    .iter_bnd_i (iter_bnd_i),
    .insn_bnd_i (insn_bnd_i),
    .go_o       (win_go),
    .abort_o    (win_abort)
  );

  tes_vec #(
    .AW(AW), .OPC_W(OPC_W), .SW(SW), .VEC_BASE(VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE), .SWAP_OP0(SWAP_OP0), .SWAP_OP1(SWAP_OP1)
  ) u_vec (
    .idx_i   (win_idx),
    .addr_o  (win_addr),
    .op_i    (fetch_data_i),
    .legal_o (op_legal),
    .sel_o   (op_sel)
  );

  assign take     = (st_q == ST_IDLE) && any_pend && win_go;
  assign pend_clr = take ? (N_SRC'(1) << win_idx) : '0;

  // requests arriving during entry stay pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | trap_req_i;
  end

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    iex_d  = iex_q;
    sel_d  = sel_q;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          st_d   = ST_FETCH;
          addr_d = win_addr;
          iex_d  = 1'b0;
        end
      end
      ST_FETCH: begin
        if (fetch_ack_i) begin
          if (op_legal) begin
            st_d  = ST_SWAP;
            sel_d = op_sel;
          end else if (iex_q) begin
            st_d = ST_HALT;
          end else begin
            addr_d = IEX_VEC;
            iex_d  = 1'b1;
          end
        end
      end
      ST_SWAP: begin
        if (swap_done_i) st_d = ST_IDLE;
      end
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      src_q  <= '0;
      iex_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      iex_q  <= iex_d;
      sel_q  <= sel_d;
      if (take) src_q <= win_idx;
    end
  end

  assign abort_o       = take && win_abort;
  assign trap_active_o = (st_q != ST_IDLE);
  assign trap_src_o    = src_q;
  assign fetch_req_o   = (st_q == ST_FETCH);
  assign fetch_addr_o  = addr_q;
  assign swap_go_o     = (st_q == ST_SWAP);
  assign swap_sel_o    = sel_q;
  assign int_ack_o     = int_req_i && (st_q == ST_IDLE);
  assign fatal_o       = (st_q == ST_HALT);
endmodule

// File: rtl/tes_chk.sv
module tes_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          abort_o,
  input logic          trap_active_o,
  input logic          fetch_req_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          fetch_ack_i,
  input logic          swap_go_o,
  input logic          swap_done_i,
  input logic          int_req_i,
  input logic          int_ack_o,
  input logic          fatal_o
);
  assert_no_ack_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_active_o |-> !int_ack_o);

  assert_ack_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_active_o && int_req_i) |-> int_ack_o);

  assert_abort_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (fetch_req_o && trap_active_o));

  assert_addr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_ack_i) |=> $stable(fetch_addr_o));

  assert_fatal_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> (fatal_o && !fetch_req_o && !swap_go_o));

  assert_swap_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_go_o |-> (!fetch_req_o && trap_active_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_go_o && swap_done_i) |=> !trap_active_o);
endmodule

bind trap_entry_seq tes_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .abort_o       (abort_o),
  .trap_active_o (trap_active_o),
  .fetch_req_o   (fetch_req_o),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_ack_i   (fetch_ack_i),
  .swap_go_o     (swap_go_o),
  .swap_done_i   (swap_done_i),
  .int_req_i     (int_req_i),
  .int_ack_o     (int_ack_o),
  .fatal_o       (fatal_o)
);

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [3:0] trap_req_i;
  logic       iter_bnd_i, insn_bnd_i;
  logic       abort_o, trap_active_o;
  logic [1:0] trap_src_o;
  logic       fetch_req_o;
  logic [11:0] fetch_addr_o;
  logic       fetch_ack_i;
  logic [7:0] fetch_data_i;
  logic       swap_go_o, swap_sel_o, swap_done_i;
  logic       int_req_i, int_ack_o, fatal_o;

  trap_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trap_req_i(trap_req_i),
    .iter_bnd_i(iter_bnd_i), .insn_bnd_i(insn_bnd_i), .abort_o(abort_o),
    .trap_active_o(trap_active_o), .trap_src_o(trap_src_o),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
    .swap_go_o(swap_go_o), .swap_sel_o(swap_sel_o), .swap_done_i(swap_done_i),
    .int_req_i(int_req_i), .int_ack_o(int_ack_o), .fatal_o(fatal_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // src, first word, second word, chained, expected abort
  typedef struct packed {
    logic [1:0] src;
    logic [7:0] op1;
    logic [7:0] op2;
    logic       chain;
    logic       ab;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{2'd0, 8'h8F, 8'h00, 1'b0, 1'b1},
    '{2'd1, 8'h8A, 8'h00, 1'b0, 1'b1},
    '{2'd2, 8'h8F, 8'h00, 1'b0, 1'b0},
    '{2'd3, 8'h8A, 8'h00, 1'b0, 1'b1},
    '{2'd0, 8'h55, 8'h8F, 1'b1, 1'b1},
    '{2'd2, 8'hFF, 8'h8A, 1'b1, 1'b0}
  };

  task automatic fetch_reply(logic [7:0] op);
    fetch_ack_i = 1'b1; fetch_data_i = op;
    @(negedge clk);
    fetch_ack_i = 1'b0;
  endtask

  task automatic finish_swap();
    swap_done_i = 1'b1;
    @(negedge clk);
    swap_done_i = 1'b0;
  endtask

  task automatic pulse_req(logic [3:0] m);
    @(negedge clk); trap_req_i = m;
    @(negedge clk); trap_req_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trap_req_i = '0; iter_bnd_i = 0; insn_bnd_i = 0;
    fetch_ack_i = 0; fetch_data_i = '0; swap_done_i = 0; int_req_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    int_req_i = 1'b1;
    #1;
    // R1 reset state
    chk("R1 idle", {trap_active_o, fetch_req_o, swap_go_o, abort_o, fatal_o}, 0);
    chk("R1 ack", int_ack_o, 1);
    int_req_i = 1'b0;

    for (int k = 0; k < 6; k++) begin
      vec_t v;
      logic [7:0] last;
      v = VT[k];
      last = v.chain ? v.op2 : v.op1;
      @(negedge clk); trap_req_i = 4'(1 << v.src);
      @(negedge clk); trap_req_i = '0; insn_bnd_i = 1'b1; int_req_i = 1'b1;
      #1;
      chk("R4 R5 R6 abort", abort_o, v.ab);
      chk("R11 ack idle", int_ack_o, 1);
      @(negedge clk); insn_bnd_i = 1'b0;
      chk("R2 vector", fetch_addr_o, 32'h040 + 2 * v.src);
      chk("R7 active", trap_active_o, 1);
      chk("R11 ack held", int_ack_o, 0);
      fetch_reply(v.op1);
      if (v.chain) begin
        chk("R9 iex fetch", {fetch_req_o, fetch_addr_o}, {1'b1, 12'h030});
        fetch_reply(v.op2);
      end
      chk("R8 swap", {swap_go_o, fetch_req_o}, 2'b10);
      chk("R8 sel", swap_sel_o, (last == 8'h8A));
      chk("R11 ack in swap", int_ack_o, 0);
      finish_swap();
      chk("R7 released", trap_active_o, 0);
      chk("R11 ack back", int_ack_o, 1);
      int_req_i = 1'b0;
    end

    // R5: iteration source waits for a boundary
    pulse_req(4'b0010);
    repeat (3) @(negedge clk);
    chk("R5 waits", trap_active_o, 0);
    iter_bnd_i = 1'b1; #1;
    chk("R5 abort", abort_o, 1);
    @(negedge clk); iter_bnd_i = 1'b0;
    chk("R5 taken", fetch_addr_o, 12'h042);
    fetch_reply(8'h8F); finish_swap();

    // R6: iteration boundary ignored for end-of-instruction source
    pulse_req(4'b0100);
    iter_bnd_i = 1'b1; #1;
    chk("R6 no abort", abort_o, 0);
    @(negedge clk); iter_bnd_i = 1'b0;
    chk("R6 ignores iter", trap_active_o, 0);
    insn_bnd_i = 1'b1; #1;
    chk("R6 no abort at end", abort_o, 0);
    @(negedge clk); insn_bnd_i = 1'b0;
    chk("R6 taken", fetch_addr_o, 12'h044);
    fetch_reply(8'h8A); finish_swap();

    // R3: lowest number first, the other stays pending
    pulse_req(4'b0110);
    insn_bnd_i = 1'b1;
    @(negedge clk); insn_bnd_i = 1'b0;
    chk("R3 first", fetch_addr_o, 12'h042);
    chk("R3 src", trap_src_o, 1);
    fetch_reply(8'h8F); finish_swap();
    insn_bnd_i = 1'b1;
    @(negedge clk); insn_bnd_i = 1'b0;
    chk("R3 second", fetch_addr_o, 12'h044);
    // R12: address held while ack is late
    repeat (3) @(negedge clk);
    chk("R12 hold", {fetch_req_o, fetch_addr_o}, {1'b1, 12'h044});
    fetch_reply(8'h8F); finish_swap();

    // R10: double illegal word halts
    pulse_req(4'b0001);
    @(negedge clk);
    fetch_reply(8'h00);
    chk("R10 iex", fetch_addr_o, 12'h030);
    fetch_reply(8'h8C);
    chk("R10 fatal", fatal_o, 1);
    trap_req_i = 4'b1000;
    repeat (4) @(negedge clk);
    trap_req_i = '0;
    chk("R10 sticky", {fatal_o, fetch_req_o, swap_go_o}, 3'b100);
    int_req_i = 1'b1; #1;
    chk("R11 halted ack", int_ack_o, 0);
    int_req_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 after reset", {fatal_o, trap_active_o}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule